// File: doc/BRIEF.md
# Dual-Issue Packet Slot Dispatcher

This block sits between instruction fetch and a two-wide execute stage of a statically scheduled core. Every cycle it can take one 64-bit packet holding two 32-bit instructions. The word at the lower address is packed in bits 31:0 and is called slot 0. The word at the upper address is packed in bits 63:32 and is called slot 1. Slot 0 is sent to the ALU/branch unit and slot 1 to the load/store unit, each with its own valid flag.

The dispatcher only checks the form of the packet. The packet address must sit on an 8-byte boundary, and each slot must hold an instruction of its own class or a nop. A packet that breaks either rule raises an error flag and issues nothing. The block has no hazard logic and decodes no operands beyond presenting the register fields. The compiler is trusted to schedule both slots and successive packets safely.

The outputs are registered and advance only when the downstream stage is ready. Both slots' source register fields are presented together, so that a register file with four read ports can serve the packet in one cycle.

Top module: `dual_slot_dispatch`

## Requirements
- R1: While `rst_n` is low, and after its release until a packet is accepted, `alu_valid`, `mem_valid` and `pkt_err` are 0.
- R2: An accepted legal packet gives, one clock later, `alu_instr` equal to bits 31:0 and `mem_instr` equal to bits 63:32. Each slot's valid flag is 1 when that slot is not a nop.
- R3: The slot class is taken from opcode bits 31:26. Opcodes 0x00 to 0x0F (register ALU, branch/jump, immediate ALU) are legal only in slot 0. Opcodes 0x20 to 0x2F (loads and stores) are legal only in slot 1. Every other opcode is legal in neither slot.
- R4: A nop is the all-zero word and is legal in either slot. A nop slot gives a valid flag of 0 and an instruction output of 0.
- R5: An accepted packet whose `pkt_addr_lo` (address bits 2:0) is nonzero gives `pkt_err`=1 with both valid flags 0 and both instruction outputs 0.
- R6: An accepted aligned packet with a slot that breaks R3 gives `pkt_err`=1 with both valid flags 0 and both instruction outputs 0. This holds even when the other slot is legal.
- R7: `pkt_ready` equals `down_ready`, and a packet is accepted when `pkt_valid` and `down_ready` are both 1. While `down_ready` is 0, every output register holds its value.
- R8: With `down_ready`=1 and `pkt_valid`=0, the next clock clears both valid flags, `pkt_err` and both instruction outputs.
- R9: The register fields are presented together each cycle. `alu_rs`/`alu_rt` are bits 25:21/20:16 of `alu_instr`, and `mem_rs`/`mem_rt` are the same fields of `mem_instr`.
- R10: No dependency check is made. A slot 1 that reads a register written by slot 0, or by the previous packet, is issued with no stall or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Fetch presents a packet |
| pkt_addr_lo | input | ALIGN_BITS (3) | Low bits of the packet fetch address |
| pkt_data | input | 64 | Packet: slot 0 in bits 31:0, slot 1 in bits 63:32 |
| pkt_ready | output | 1 | Packet is taken this cycle if valid |
| down_ready | input | 1 | Both execute units can take a packet |
| alu_valid | output | 1 | ALU/branch slot carries an instruction |
| alu_instr | output | 32 | ALU/branch slot word |
| mem_valid | output | 1 | Load/store slot carries an instruction |
| mem_instr | output | 32 | Load/store slot word |
| pkt_err | output | 1 | Last accepted packet broke the slot or alignment rules |
| alu_rs | output | 5 | Slot 0 first source register field |
| alu_rt | output | 5 | Slot 0 second source register field |
| mem_rs | output | 5 | Slot 1 base register field |
| mem_rt | output | 5 | Slot 1 data register field |

## Verification
On every cycle the assertions check the following:
- an error never comes with an issued slot;
- an issued slot is never a nop and always carries an opcode of its own class;
- a misaligned accepted packet always produces an error;
- the outputs stay frozen while the downstream stage stalls.

The bench's scenarios show the rest: the exact words and register fields after each packet, the clearing on idle cycles, back-to-back issue of dependent packets, and the mapping of each opcode range to its slot.

// File: rtl/dual_slot_dispatch.sv
module dual_slot_dispatch #(
  parameter int ALIGN_BITS = 3,
  parameter int WORD_W = 32,
  parameter int REG_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_valid,
  input  logic [ALIGN_BITS-1:0] pkt_addr_lo,
  input  logic [2*WORD_W-1:0]   pkt_data,
  output logic                  pkt_ready,
  input  logic                  down_ready,
  output logic                  alu_valid,
  output logic [WORD_W-1:0]     alu_instr,
  output logic                  mem_valid,
  output logic [WORD_W-1:0]     mem_instr,
  output logic                  pkt_err,
  output logic [REG_W-1:0]      alu_rs,
  output logic [REG_W-1:0]      alu_rt,
  output logic [REG_W-1:0]      mem_rs,
  output logic [REG_W-1:0]      mem_rt
);
  localparam int OP_HI = WORD_W - 1;
  localparam int RS_LO = WORD_W - 6 - REG_W;
  localparam int RT_LO = RS_LO - REG_W;

  logic [WORD_W-1:0] s0, s1;
  logic s0_nop, s1_nop, s0_ok, s1_ok, aligned, good, take;

  assign s0 = pkt_data[WORD_W-1:0];
  assign s1 = pkt_data[2*WORD_W-1:WORD_W];
  assign s0_nop = (s0 == '0);
  assign s1_nop = (s1 == '0);
  assign s0_ok = s0_nop || (s0[OP_HI -: 2] == 2'b00);
  assign s1_ok = s1_nop || (s1[OP_HI -: 2] == 2'b10);
  assign aligned = (pkt_addr_lo == '0);
  assign good = aligned && s0_ok && s1_ok;
  assign take = pkt_valid && good;
  assign pkt_ready = down_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alu_valid <= 1'b0;
      mem_valid <= 1'b0;
      pkt_err   <= 1'b0;
      alu_instr <= '0;
      mem_instr <= '0;
    end else if (down_ready) begin
      alu_valid <= take && !s0_nop;
      mem_valid <= take && !s1_nop;
      pkt_err   <= pkt_valid && !good;
      alu_instr <= take ? s0 : '0;
      mem_instr <= take ? s1 : '0;
    end
  end

  assign alu_rs = alu_instr[RS_LO +: REG_W];
  assign alu_rt = alu_instr[RT_LO +: REG_W];
  assign mem_rs = mem_instr[RS_LO +: REG_W];
  assign mem_rt = mem_instr[RT_LO +: REG_W];

  // R5 R6
  err_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |-> !alu_valid && !mem_valid);

  // R3 R4
  alu_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid |-> alu_instr != '0 && alu_instr[OP_HI -: 2] == 2'b00);

  // R3 R4
  mem_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_instr[OP_HI -: 2] == 2'b10);

  // R5
  misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && down_ready && pkt_addr_lo != '0 |=> pkt_err && !alu_valid && !mem_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !down_ready |=> $stable(alu_instr) && $stable(mem_instr) && $stable(alu_valid)
                    && $stable(mem_valid) && $stable(pkt_err));

  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    down_ready && !pkt_valid |=> !alu_valid && !mem_valid && !pkt_err);
endmodule

// File: tb/test_dual_slot_dispatch.sv
`timescale 1ns/1ps
module test_dual_slot_dispatch;
  logic clk = 1'b0, rst_n = 1'b0, pkt_valid = 1'b0, down_ready = 1'b0;
  logic [2:0] pkt_addr_lo = '0;
  logic [63:0] pkt_data = '0;
  logic pkt_ready, alu_valid, mem_valid, pkt_err;
  logic [31:0] alu_instr, mem_instr;
  logic [4:0] alu_rs, alu_rt, mem_rs, mem_rt;

  int checks = 0, errors = 0;
  logic e_av = 0, e_mv = 0, e_err = 0;
  logic [31:0] e_ai = 0, e_mi = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_slot_dispatch i_dual_slot_dispatch (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_addr_lo(pkt_addr_lo),
    .pkt_data(pkt_data), .pkt_ready(pkt_ready), .down_ready(down_ready),
    .alu_valid(alu_valid), .alu_instr(alu_instr), .mem_valid(mem_valid),
    .mem_instr(mem_instr), .pkt_err(pkt_err), .alu_rs(alu_rs), .alu_rt(alu_rt),
    .mem_rs(mem_rs), .mem_rt(mem_rt));

  function automatic bit legal(input logic [31:0] w, input bit upper);
    int op = int'(w[31:26]);
    if (w == 0) return 1;
    if (upper) return op >= 32 && op < 48;
    return op < 16;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "alu_valid", 32'(alu_valid), 32'(e_av));
    chk(tag, "mem_valid", 32'(mem_valid), 32'(e_mv));
    chk(tag, "pkt_err", 32'(pkt_err), 32'(e_err));
    chk(tag, "alu_instr", alu_instr, e_ai);
    chk(tag, "mem_instr", mem_instr, e_mi);
    chk("R9", "alu_rs", 32'(alu_rs), 32'(e_ai[25:21]));
    chk("R9", "alu_rt", 32'(alu_rt), 32'(e_ai[20:16]));
    chk("R9", "mem_rs", 32'(mem_rs), 32'(e_mi[25:21]));
    chk("R9", "mem_rt", 32'(mem_rt), 32'(e_mi[20:16]));
  endtask

  task automatic step(input logic v, input logic [2:0] a, input logic [63:0] d,
                      input logic r, input string tag);
    logic ok;
    pkt_valid = v; pkt_addr_lo = a; pkt_data = d; down_ready = r;
    #1;
    chk("R7", "pkt_ready", 32'(pkt_ready), 32'(r));
    if (r) begin
      ok = (a == 0) && legal(d[31:0], 0) && legal(d[63:32], 1);
      e_err = v && !ok;
      e_ai = (v && ok) ? d[31:0] : 0;
      e_mi = (v && ok) ? d[63:32] : 0;
      e_av = e_ai != 0;
      e_mv = e_mi != 0;
    end
    @(posedge clk); @(negedge clk);
    check_all(tag);
  endtask

  function automatic logic [31:0] mk(input int op);
    logic [31:0] w = $urandom;
    w[31:26] = 6'(op);
    if (w == 0) w[0] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] rnd_word(input bit upper);
    int k = $urandom_range(0, 9);
    if (k == 0) return 0;
    if (k == 1) return mk($urandom_range(16, 31));
    if (k == 2) return mk($urandom_range(48, 63));
    if (k == 3) return mk(upper ? $urandom_range(0, 15) : $urandom_range(32, 47));
    return mk(upper ? $urandom_range(32, 47) : $urandom_range(0, 15));
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    step(1'b0, 3'd0, 64'd0, 1'b1, "R1");
    // R2 legal pair: addu then lw
    step(1'b1, 3'd0, {32'h8D28_0004, 32'h0109_4021}, 1'b1, "R2");
    // R4 nop in either slot
    step(1'b1, 3'd0, {32'h0, 32'h2129_0008}, 1'b1, "R4");
    step(1'b1, 3'd0, {32'hAD09_0000, 32'h0}, 1'b1, "R4");
    step(1'b1, 3'd0, 64'd0, 1'b1, "R4");
    // R5 misaligned
    step(1'b1, 3'd4, {32'h8D28_0004, 32'h0109_4021}, 1'b1, "R5");
    step(1'b1, 3'd1, {32'h8D28_0004, 32'h0109_4021}, 1'b1, "R5");
    // R6 swapped classes and illegal opcodes
    step(1'b1, 3'd0, {32'h0109_4021, 32'h8D28_0004}, 1'b1, "R6");
    step(1'b1, 3'd0, {32'h8D28_0004, 32'h4000_0001}, 1'b1, "R6");
    step(1'b1, 3'd0, {32'hFC00_0001, 32'h0109_4021}, 1'b1, "R6");
    // R3 range edges
    step(1'b1, 3'd0, {32'hBC00_0001, 32'h3C00_0001}, 1'b1, "R3");
    step(1'b1, 3'd0, {32'h8000_0001, 32'h0400_0001}, 1'b1, "R3");
    step(1'b1, 3'd0, {32'hC000_0001, 32'h0000_0001}, 1'b1, "R3");
    // R7 stall holds
    step(1'b1, 3'd0, {32'h8D28_0004, 32'h0109_4021}, 1'b1, "R7");
    step(1'b1, 3'd0, {32'hAD09_0000, 32'h2129_0008}, 1'b0, "R7");
    step(1'b1, 3'd2, {32'hAD09_0000, 32'h2129_0008}, 1'b0, "R7");
    step(1'b1, 3'd0, {32'hAD09_0000, 32'h2129_0008}, 1'b1, "R7");
    // R8 idle clears
    step(1'b0, 3'd0, {32'hAD09_0000, 32'h2129_0008}, 1'b1, "R8");
    // R10 dependent slots and packets issue back to back
    step(1'b1, 3'd0, {32'hAD09_0000, 32'h0109_4821}, 1'b1, "R10");
    step(1'b1, 3'd0, {32'h8D28_0000, 32'h0129_4821}, 1'b1, "R10");
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] d = {rnd_word(1), rnd_word(0)};
      logic [2:0] a = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'd0;
      step(($urandom_range(0, 5) != 0), a, d, ($urandom_range(0, 3) != 0), "R2");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule